// File: doc/BRIEF.md
# Four-Round 16-bit Feistel Block Cipher Engine

This block encrypts or decrypts one 16-bit block under an 8-bit key. The network has four rounds and the block runs one round per clock. A one-cycle start strobe captures the data word, the key and the direction bit. A small state machine then steps a round counter through four rounds. While it does so, a rotation network derives each round key from the captured key.

When the last round finishes, the block writes the result to an output register and raises a one-cycle done pulse. The result then stays stable until a later operation completes. Decryption runs the same hardware with the key order reversed and the inverse half-update, so `decrypt(encrypt(p, k), k) == p`. A start strobe that arrives while the engine is busy has no effect.

The state machine has three states:
- `ST_IDLE` waits for a start strobe (transition *accept*: start seen, so the inputs are latched and the counter is cleared).
- `ST_ROUND` applies one round per cycle (transition *step*: counter below 3, so it stays and increments; transition *finish*: counter at 3, so it writes the result and moves on).
- `ST_DONE` asserts done for exactly one cycle (transition *release*: back to `ST_IDLE` unconditionally).

Top module: `fk_cipher16`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 16'h0000.
- R2: The 16-bit word is split into a left half in bits [15:8] and a right half in bits [7:0]. The output holds the left half after round 4 in bits [15:8] and the right half after round 4 in bits [7:0], with no extra final swap. Under key 8'h00, the plaintext 16'h0000 encrypts to 16'h00FF.
- R3: The round function on 8 bits is F(x, k) = x XOR (NOT k).
- R4: The key for round i (i = 0..3) is the input key rotated left by i bit positions, with the MSB wrapping into the LSB.
- R5: With `mode_i` = 0 (encrypt), each round maps (L, R) to (R, L XOR F(R, k_i)), using keys k_0, k_1, k_2, k_3 in that order.
- R6: With `mode_i` = 1 (decrypt), each round maps (L, R) to (R XOR F(L, k_i), L), using keys k_3 down to k_0. Decrypting a ciphertext with its key returns the plaintext.
- R7: A start strobe sampled in `ST_IDLE` at clock edge t makes `done_o` high for exactly one cycle, directly after edge t+4.
- R8: `result_o` changes only in the cycle where `done_o` is high. Otherwise it holds the last result.
- R9: A start strobe sampled while an operation is running, or in its done cycle, is ignored. It does not alter the result and does not cause an extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| mode_i | input | 1 | 0 = encrypt, 1 = decrypt |
| data_i | input | 16 | Plaintext or ciphertext block |
| key_i | input | 8 | Master key |
| result_o | output | 16 | Result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong round counter or a wrong key index shows up as a wrong `result_o` in the same cycle `done_o` rises, four edges after the accepting edge. A wrong rotation direction shows only for keys whose bits are not all equal, so the random keys and the 8'h80 wrap case matter. A state machine that re-accepts start while busy shows up either as a second done pulse within a few cycles or as a result computed from the second set of inputs. A wrong decrypt path shows up as a failed round trip on the next operation.

// File: rtl/fk_pkg.sv
package fk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_DONE  = 2'd2
    } fk_state_e;
endpackage

// File: rtl/fk_keysched.sv
module fk_keysched #(
    parameter int unsigned KEY_W = 8,
    parameter int unsigned IDX_W = 2
) (
    input  logic [KEY_W-1:0] mkey_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [KEY_W-1:0] rkey_o
);
    logic [2*KEY_W-1:0] doubled;

    // left rotation: upper half of the doubled key shifted left
    always_comb begin
        doubled = {mkey_i, mkey_i} << idx_i;
        rkey_o  = doubled[2*KEY_W-1:KEY_W];
    end
endmodule

// File: rtl/fk_round.sv
module fk_round #(
    parameter int unsigned HALF_W = 8
) (
    input  logic              decrypt_i,
    input  logic [HALF_W-1:0] left_i,
    input  logic [HALF_W-1:0] right_i,
    input  logic [HALF_W-1:0] rkey_i,
    output logic [HALF_W-1:0] left_o,
    output logic [HALF_W-1:0] right_o
);
    logic [HALF_W-1:0] f_in;
    logic [HALF_W-1:0] f_out;

    always_comb begin
        f_in  = decrypt_i ? left_i : right_i;
        f_out = f_in ^ ~rkey_i;
        if (decrypt_i) begin
            left_o  = right_i ^ f_out;
            right_o = left_i;
        end else begin
            left_o  = right_i;
            right_o = left_i ^ f_out;
        end
    end
endmodule

// File: rtl/fk_cipher16.sv
module fk_cipher16 #(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned ROUNDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [2*HALF_W-1:0] data_i,
    input  logic [HALF_W-1:0]   key_i,
    output logic [2*HALF_W-1:0] result_o,
    output logic                done_o
);
    import fk_pkg::*;

    localparam int unsigned BLK_W = 2 * HALF_W;
    localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    fk_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  key_idx;
    logic              dec_q;
    logic [HALF_W-1:0] key_q;
    logic [HALF_W-1:0] left_q, right_q;
    logic [HALF_W-1:0] left_n, right_n;
    logic [HALF_W-1:0] rkey;
    logic [BLK_W-1:0]  res_q;
    logic              accept;
    logic              last_rnd;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign last_rnd = (cnt_q == LAST_RND);
    assign key_idx  = dec_q ? (LAST_RND - cnt_q) : cnt_q;

    fk_keysched #(.KEY_W(HALF_W), .IDX_W(CNT_W)) u_keys (
        .mkey_i (key_q),
        .idx_i  (key_idx),
        .rkey_o (rkey)
    );

    fk_round #(.HALF_W(HALF_W)) u_round (
        .decrypt_i (dec_q),
        .left_i    (left_q),
        .right_i   (right_q),
        .rkey_i    (rkey),
        .left_o    (left_n),
        .right_o   (right_n)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ROUND;
            ST_ROUND: if (last_rnd) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dec_q   <= 1'b0;
            key_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
            res_q   <= '0;
        end else if (accept) begin
            cnt_q   <= '0;
            dec_q   <= mode_i;
            key_q   <= key_i;
            left_q  <= data_i[BLK_W-1:HALF_W];
            right_q <= data_i[HALF_W-1:0];
        end else if (state_q == ST_ROUND) begin
            cnt_q   <= cnt_q + 1'b1;
            left_q  <= left_n;
            right_q <= right_n;
            if (last_rnd) res_q <= {left_n, right_n};
        end
    end

    // outputs
    always_comb begin
        done_o   = (state_q == ST_DONE);
        result_o = res_q;
    end
endmodule

// File: rtl/fk_cipher16_chk.sv
module fk_cipher16_chk #(
    parameter int unsigned HALF_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                done_o,
    input logic [2*HALF_W-1:0] result_o,
    input logic [HALF_W-1:0]   rkey,
    input logic [HALF_W-1:0]   key_q,
    input fk_pkg::fk_state_e   state_q
);
    import fk_pkg::*;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q) == ST_ROUND);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    // R4
    key_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROUND) |-> $countones(rkey) == $countones(key_q));

    // R9
    busy_key_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(key_q));
endmodule

bind fk_cipher16 fk_cipher16_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .result_o (result_o),
    .rkey     (rkey),
    .key_q    (key_q),
    .state_q  (state_q)
);

// File: tb/tb_fk_cipher16.sv
`timescale 1ns/1ps
module tb_fk_cipher16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [7:0]  key_i = '0;
    logic [15:0] result_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fk_cipher16 dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .data_i(data_i), .key_i(key_i), .result_o(result_o), .done_o(done_o)
    );

    function automatic logic [7:0] rotl(input logic [7:0] k, input int n);
        logic [7:0] r = k;
        for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
        return r;
    endfunction

    function automatic logic [15:0] ref_enc(input logic [15:0] p, input logic [7:0] k);
        logic [7:0] l = p[15:8], r = p[7:0], t;
        for (int i = 0; i < 4; i++) begin
            t = l ^ (r ^ ~rotl(k, i));
            l = r;
            r = t;
        end
        return {l, r};
    endfunction

    function automatic logic [15:0] ref_dec(input logic [15:0] c, input logic [7:0] k);
        logic [7:0] l = c[15:8], r = c[7:0], t;
        for (int i = 3; i >= 0; i--) begin
            t = r ^ (l ^ ~rotl(k, i));
            r = l;
            l = t;
        end
        return {l, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic m, input logic [15:0] d, input logic [7:0] k,
                          output logic [15:0] res, output int lat);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; data_i = d; key_i = k;
        lat = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (done_o) break;
        end
        res = result_o;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] res, res2, p, c, held;
        logic [7:0]  k;
        int lat, extra;
        void'($urandom(32'h5EED1234));

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {31'b0, done_o}, 32'd0);
        check("R1 result", {16'b0, result_o}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 directed known vector
        run_op(1'b0, 16'h0000, 8'h00, res, lat);
        check("R2 zero vector", {16'b0, res}, 32'h00FF);
        check("R7 latency", lat, 5);
        // R7 one-cycle pulse
        @(negedge clk);
        check("R7 pulse width", {31'b0, done_o}, 32'd0);

        // R4 wrap of MSB
        run_op(1'b0, 16'h1234, 8'h80, res, lat);
        check("R4 key wrap", {16'b0, res}, {16'b0, ref_enc(16'h1234, 8'h80)});
        run_op(1'b0, 16'hFFFF, 8'hFF, res, lat);
        check("R3 all ones", {16'b0, res}, {16'b0, ref_enc(16'hFFFF, 8'hFF)});
        run_op(1'b1, 16'h00FF, 8'h00, res, lat);
        check("R6 known decrypt", {16'b0, res}, 32'h0000);

        // random encryption and round trip
        for (int i = 0; i < 40; i++) begin
            p = 16'($urandom);
            k = 8'($urandom);
            run_op(1'b0, p, k, c, lat);
            check("R5 encrypt", {16'b0, c}, {16'b0, ref_enc(p, k)});
            check("R7 latency", lat, 5);
            run_op(1'b1, c, k, res, lat);
            check("R6 round trip", {16'b0, res}, {16'b0, p});
            check("R6 decrypt model", {16'b0, res}, {16'b0, ref_dec(c, k)});
        end

        // R8 hold after done
        held = result_o;
        repeat (10) @(negedge clk);
        check("R8 hold idle", {16'b0, result_o}, {16'b0, held});

        // R9 start while running is ignored; R8 result held during run
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0; data_i = 16'hA5C3; key_i = 8'h5A;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R8 hold while running", {16'b0, result_o}, {16'b0, held});
        start_i = 1'b1; data_i = 16'h0F0F; key_i = 8'h33; mode_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        res = result_o;
        check("R9 busy start ignored", {16'b0, res}, {16'b0, ref_enc(16'hA5C3, 8'h5A)});
        // start during done cycle is ignored too
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check("R9 no extra done", extra, 0);
        check("R9 result kept", {16'b0, result_o}, {16'b0, res});

        // R8 a new operation replaces the result
        run_op(1'b0, 16'hBEEF, 8'h01, res2, lat);
        check("R8 new result", {16'b0, res2}, {16'b0, ref_enc(16'hBEEF, 8'h01)});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule